// File: doc/BRIEF.md
# I2C Bus Event Status Monitor

This block listens to the clock and data lines of an I2C bus from the side, without driving them. A fast system clock oversamples both lines. The block picks out start conditions, stop conditions and acknowledge bits. It keeps three sticky flags: acknowledge seen, start seen and stop seen. Software or a neighbouring controller reads these flags to follow where a transfer is on the bus.

Each flag is cleared by its own set of events, and those events depend on bus position. Examples are the first clock of the following byte, the first clock of an address byte, a strobe that leaves the transfer, or the falling edge of a wake-up mode bit. To tell the ninth (acknowledge) clock apart from the first clock of the next byte, the block counts clock pulses within each byte and shows the count.

A small configuration register of two bits also lives here: a reservation-allow bit and an initial-busy bit. It accepts writes only while the monitor is disabled. The monitor does not use these bits itself.

Top module: `i2c_event_monitor`

## Requirements
- R1: After synchronous reset, all three flags are 0, the bit count is 0 and the configuration bits are 0.
- R2: A start condition (data falling while clock stays high) sets the start flag and forces the bit count to 0. Both lines pass through a two-flop synchronizer, so a line change shows in the outputs at the third rising system-clock edge after it.
- R3: Each rising edge of the bus clock advances the bit count. The count goes 0 to 1 after a start, then 1 up to 9, and from 9 it wraps to 1. The count never exceeds 9.
- R4: The acknowledge flag sets when data is low at the rising edge that takes the count from 8 to 9. If data is high there, the flag stays clear.
- R5: The acknowledge flag clears at the rising edge that takes the count from 9 to 1, on a stop condition, and on a one-cycle pulse of leave_i.
- R6: The start flag clears at the rising edge that takes the count from 9 to 1, on a stop condition, and on leave_i.
- R7: A stop condition (data rising while clock stays high) sets the stop flag.
- R8: The stop flag clears only at the first bus-clock rising edge after a start that came later than the stop. A start alone leaves it set, and so does a clock edge with no start before it.
- R9: The stop flag clears on a 1-to-0 edge of wake_i. A rising edge of wake_i and the leave_i pulse leave it unchanged.
- R10: When a set event and a clear event reach the same flag in the same cycle, the set event wins. For example, the acknowledge flag sets even if leave_i is high in that cycle.
- R11: While en_i is 0, all flags and the bit count are held at 0 and bus events are ignored. A falling en_i therefore clears everything on the next edge.
- R12: cfg_we_i writes cfg_wdata_i into cfg_o only while en_i is 0. Bit 0 is the reservation-allow bit and bit 1 is the initial-busy bit. While enabled, writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Monitor enable |
| leave_i | input | 1 | One-cycle strobe to leave the current transfer |
| wake_i | input | 1 | Wake-up mode bit; its falling edge clears the stop flag |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 2 | Configuration write data |
| ack_o | output | 1 | Acknowledge-seen flag |
| start_o | output | 1 | Start-seen flag (address byte in progress) |
| stop_o | output | 1 | Stop-seen flag |
| bit_cnt_o | output | 4 | Bus-clock pulse count within the byte (0, 1..9) |
| cfg_o | output | 2 | Configuration bits |

## Verification
On every cycle, the assertions check the cycle-local rules. These are: each detected bus event sets its flag one cycle later, count stepping and wrap, clearing at the wrap edge, set-over-leave priority, the wake edge, holding at zero while disabled, and the configuration lock. What only the bench's scenarios can show are whole transfer sequences at the pins, seen through the synchronizer. Examples are the stop flag surviving a later start and then clearing at the first address clock, the stop flag staying set across a stray clock with no start, the acknowledge flag clearing on a stop raised directly after the ninth clock, and a leave pulse timed to land on the same cycle as the acknowledge edge.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ACK_SLOT  = BYTE_BITS + 1;
    localparam int CNT_W     = $clog2(ACK_SLOT + 1);

    typedef logic [CNT_W-1:0] bitcnt_t;

    // Single-cycle bus events in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda_lvl;
    } bus_evt_t;

    typedef struct packed {
        logic ack;
        logic start;
        logic stop;
    } flags_t;

    typedef struct packed {
        logic busy_init;
        logic rsv_ok;
    } cfg_t;

    function automatic bitcnt_t next_slot(bitcnt_t c);
        return (c == bitcnt_t'(ACK_SLOT)) ? bitcnt_t'(1) : c + bitcnt_t'(1);
    endfunction

    // Sticky bit update: set has priority over clear
    function automatic logic settle(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 1) begin : g_one
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= RST_VAL;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cmon_edge.sv
module i2cmon_edge
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    // Idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    logic scl_held;
    assign scl_held = scl & scl_q;

    always_comb begin
        evt.scl_rise = scl & ~scl_q;
        evt.start    = scl_held & sda_q & ~sda;
        evt.stop     = scl_held & ~sda_q & sda;
        evt.sda_lvl  = sda;
    end
endmodule

// File: rtl/i2cmon_bitcnt.sv
module i2cmon_bitcnt
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    start_ev,
    input  logic    rise_ev,
    output bitcnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst || !en)    cnt <= '0;
        else if (start_ev) cnt <= '0;
        else if (rise_ev)  cnt <= next_slot(cnt);
    end
endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     leave,
    input  logic     wake,
    input  bus_evt_t evt,
    input  bitcnt_t  cnt,
    output flags_t   flags
);
    flags_t nxt;
    logic   armed;
    logic   armed_n;
    logic   wake_q;
    logic   wake_fall;
    logic   rise_first;
    logic   rise_addr;
    logic   ack_set, ack_clr;
    logic   sta_set, sta_clr;
    logic   sto_set, sto_clr;

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= wake;
    end

    always_comb begin
        wake_fall  = wake_q & ~wake;
        rise_first = evt.scl_rise && (cnt == bitcnt_t'(ACK_SLOT));
        rise_addr  = evt.scl_rise && (cnt == '0);

        ack_set = evt.scl_rise && (cnt == bitcnt_t'(BYTE_BITS)) && !evt.sda_lvl;
        ack_clr = evt.stop | rise_first | leave;

        sta_set = evt.start;
        sta_clr = evt.stop | rise_first | leave;

        sto_set = evt.stop;
        sto_clr = (armed & rise_addr) | wake_fall;

        nxt.ack   = settle(flags.ack,   ack_set, ack_clr);
        nxt.start = settle(flags.start, sta_set, sta_clr);
        nxt.stop  = settle(flags.stop,  sto_set, sto_clr);

        // Armed: a start has followed the latest stop
        if (sto_set)        armed_n = 1'b0;
        else if (evt.start) armed_n = 1'b1;
        else if (sto_clr)   armed_n = 1'b0;
        else                armed_n = armed;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            flags <= '0;
            armed <= 1'b0;
        end else begin
            flags <= nxt;
            armed <= armed_n;
        end
    end
endmodule

// File: rtl/i2c_event_monitor.sv
module i2c_event_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             leave_i,
    input  logic             wake_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_wdata_i,
    output logic             ack_o,
    output logic             start_o,
    output logic             stop_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [1:0]       cfg_o
);
    logic [1:0] lines_s;
    bus_evt_t   evt;
    bitcnt_t    cnt_q;
    flags_t     flags_q;
    cfg_t       cfg_q;

    i2cmon_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_s)
    );

    i2cmon_edge u_edge (
        .clk (clk),
        .rst (rst),
        .scl (lines_s[1]),
        .sda (lines_s[0]),
        .evt (evt)
    );

    i2cmon_bitcnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .start_ev (evt.start),
        .rise_ev  (evt.scl_rise),
        .cnt      (cnt_q)
    );

    i2cmon_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .en    (en_i),
        .leave (leave_i),
        .wake  (wake_i),
        .evt   (evt),
        .cnt   (cnt_q),
        .flags (flags_q)
    );

    // Configuration bits are writable only while the monitor is off
    always_ff @(posedge clk) begin
        if (rst)                    cfg_q <= '0;
        else if (cfg_we_i && !en_i) cfg_q <= cfg_t'(cfg_wdata_i);
    end

    assign ack_o     = flags_q.ack;
    assign start_o   = flags_q.start;
    assign stop_o    = flags_q.stop;
    assign bit_cnt_o = cnt_q;
    assign cfg_o     = cfg_q;
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk
    import i2cmon_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     en,
    input logic     leave,
    input logic     wake,
    input bus_evt_t evt,
    input logic     ack,
    input logic     sta,
    input logic     sto,
    input bitcnt_t  cnt,
    input logic [1:0] cfg
);
    logic wake_q;
    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= wake;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (!ack && !sta && !sto && cnt == '0 && cfg == 2'b00));

    p_start_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (en && evt.start) |=> (sta && cnt == '0));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= bitcnt_t'(ACK_SLOT));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && evt.scl_rise) |=>
        (cnt == (($past(cnt) == bitcnt_t'(ACK_SLOT)) ? bitcnt_t'(1) : $past(cnt) + bitcnt_t'(1))));

    p_ack_set_r4: assert property (@(posedge clk) disable iff (rst)
        (en && evt.scl_rise && cnt == bitcnt_t'(BYTE_BITS) && !evt.sda_lvl) |=> ack);

    p_ack_wrap_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (en && evt.scl_rise && cnt == bitcnt_t'(ACK_SLOT)) |=> !ack);

    p_ack_leave_r5: assert property (@(posedge clk) disable iff (rst)
        (en && leave && !(evt.scl_rise && cnt == bitcnt_t'(BYTE_BITS))) |=> !ack);

    p_start_wrap_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (en && evt.scl_rise && cnt == bitcnt_t'(ACK_SLOT)) |=> !sta);

    p_stop_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (en && evt.stop) |=> sto);

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (en && sto && !evt.scl_rise && !(wake_q && !wake)) |=> sto);

    p_wake_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (en && wake_q && !wake && !evt.stop) |=> !sto);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (en && leave && evt.start) |=> sta);

    p_off_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ack && !sta && !sto && cnt == '0));

    p_cfg_lock_r12: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg));
endmodule

bind i2c_event_monitor i2cmon_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en_i),
    .leave (leave_i),
    .wake  (wake_i),
    .evt   (evt),
    .ack   (ack_o),
    .sta   (start_o),
    .sto   (stop_o),
    .cnt   (bit_cnt_o),
    .cfg   (cfg_o)
);

// File: tb/sim_i2c_event_monitor.sv
module sim_i2c_event_monitor;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic       leave_i = 1'b0;
    logic       wake_i = 1'b0;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_wdata_i = 2'b00;
    logic       ack_o, start_o, stop_o;
    logic [3:0] bit_cnt_o;
    logic [1:0] cfg_o;

    always #10 clk = ~clk;   // 50 MHz

    i2c_event_monitor u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .leave_i(leave_i), .wake_i(wake_i),
        .scl_i(scl_i), .sda_i(sda_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .ack_o(ack_o), .start_o(start_o), .stop_o(stop_o),
        .bit_cnt_o(bit_cnt_o), .cfg_o(cfg_o)
    );

    typedef struct packed {
        logic       a;
        logic       s;
        logic       p;
        logic [3:0] c;
        logic [1:0] g;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  [1:0] cfg_model = 2'b00;
    bit    done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic a, input logic s, input logic p,
                              input int c, input string tag);
        exp_t e;
        e.a = a; e.s = s; e.p = p; e.c = 4'(c); e.g = cfg_model;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectations against the outputs
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (ack_o !== e.a || start_o !== e.s || stop_o !== e.p ||
                bit_cnt_o !== e.c || cfg_o !== e.g) begin
                n_bad++;
                $display("FAIL %s: got a=%b s=%b p=%b cnt=%0d cfg=%b expected a=%b s=%b p=%b cnt=%0d cfg=%b",
                         t, ack_o, start_o, stop_o, bit_cnt_o, cfg_o,
                         e.a, e.s, e.p, e.c, e.g);
            end
        end
    end

    task automatic lines(input logic c, input logic d);
        scl_i = c; sda_i = d; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_i = b; tick(HALF);
        scl_i = 1'b1; tick(HALF);
        scl_i = 1'b0; tick(HALF);
    endtask

    task automatic bus_start;   // from scl high, sda high
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
    endtask

    task automatic pulse_leave;
        leave_i = 1'b1; tick(1);
        leave_i = 1'b0; tick(2);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        expect_out(0, 0, 0, 0, "R1 reset state");

        // R12: write while disabled, then blocked while enabled
        cfg_wdata_i = 2'b01; cfg_we_i = 1'b1; tick(1); cfg_we_i = 1'b0;
        cfg_model = 2'b01; tick(1);
        expect_out(0, 0, 0, 0, "R12 write while disabled");
        en_i = 1'b1; tick(1);
        cfg_wdata_i = 2'b10; cfg_we_i = 1'b1; tick(1); cfg_we_i = 1'b0; tick(1);
        expect_out(0, 0, 0, 0, "R12 write ignored while enabled");
        tick(HALF);

        bus_start;
        expect_out(0, 1, 0, 0, "R2 start sets flag");
        scl_i = 1'b0; tick(HALF);

        send_bit(1'b1);
        expect_out(0, 1, 0, 1, "R3 first address clock");
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        send_bit(1'b1);
        expect_out(0, 1, 0, 8, "R3 eighth clock");
        send_bit(1'b0);
        expect_out(1, 1, 0, 9, "R4 ack low on ninth clock");

        send_bit(1'b1);
        expect_out(0, 0, 0, 1, "R5 R6 cleared by first clock of next byte");
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        send_bit(1'b1);
        expect_out(0, 0, 0, 9, "R4 nack leaves flag clear");

        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        expect_out(1, 0, 0, 9, "R4 ack on data byte");
        pulse_leave;
        expect_out(0, 0, 0, 9, "R5 leave clears ack");

        // stop: sda low, scl high (wraps count), sda high
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        expect_out(0, 0, 1, 1, "R7 stop sets flag");

        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        expect_out(0, 0, 1, 2, "R8 clock without start keeps stop");
        pulse_leave;
        expect_out(0, 0, 1, 2, "R9 leave does not touch stop");

        lines(1'b1, 1'b0);
        expect_out(0, 1, 1, 0, "R8 stop kept across later start");
        scl_i = 1'b0; tick(HALF);
        send_bit(1'b0);
        expect_out(0, 1, 0, 1, "R8 cleared at first address clock");
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        sda_i = 1'b0; tick(HALF);
        scl_i = 1'b1; tick(HALF);
        expect_out(1, 1, 0, 9, "R4 ack before direct stop");
        sda_i = 1'b1; tick(HALF);
        expect_out(0, 0, 1, 9, "R5 R6 R7 stop clears ack and start");

        wake_i = 1'b1; tick(3);
        expect_out(0, 0, 1, 9, "R9 wake rising no effect");
        wake_i = 1'b0; tick(3);
        expect_out(0, 0, 0, 9, "R9 wake falling clears stop");

        // R10: leave pulse lands on the ack edge
        lines(1'b1, 1'b0);
        expect_out(0, 1, 0, 0, "R2 second start");
        scl_i = 1'b0; tick(HALF);
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        sda_i = 1'b0; tick(HALF);
        scl_i = 1'b1;          // rise seen in design on the third edge
        tick(2);
        leave_i = 1'b1; tick(1);
        leave_i = 1'b0; tick(HALF);
        expect_out(1, 0, 0, 9, "R10 ack set beats leave");

        sda_i = 1'b1; tick(HALF);
        sda_i = 1'b0; tick(HALF);
        expect_out(0, 1, 1, 0, "R7 R2 stop then start");
        en_i = 1'b0; tick(2);
        expect_out(0, 0, 0, 0, "R11 disable clears all");
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        expect_out(0, 0, 0, 0, "R11 bus events ignored while off");
        en_i = 1'b1; tick(HALF);
        expect_out(0, 0, 0, 0, "R11 re-enable starts clean");

        tick(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule